// File: doc/BRIEF.md
# Displacement Load Unit

This block executes register-plus-displacement load instructions for a 32-bit core. It accepts a two-halfword instruction together with the value of its base register and a valid strobe. It decodes the load kind, then computes the effective address as the base value plus the sign-extended 16-bit displacement. It issues a read on a simple synchronous data-memory port and returns a word, a sign-extended halfword or a zero-extended halfword to the destination register.

A single major opcode serves two load kinds. The least significant displacement bit selects between them, so displacements are always even and that bit is cleared before the address sum. Accesses that are not naturally aligned raise a misalignment flag instead of reaching memory. The unit is fully pipelined and accepts one load per clock.

Top module: `ldu_top`

## Requirements
- R1: The effective address on `mem_addr` equals the base value plus the displacement (second halfword) with bit 0 cleared and sign-extended from bit 15 to 32 bits. The sum wraps modulo 2^32.
- R2: The first halfword holds the destination index in bits 15:11, the opcode in bits 10:5 and the base index in bits 4:0. Opcode 6'b111001 with displacement bit 0 = 0 is a signed halfword load: `mem_size` = 2'b01 and the 16-bit datum is sign-extended.
- R3: Opcode 6'b111001 with displacement bit 0 = 1 is a word load: `mem_size` = 2'b10 and all 32 bits are written back unchanged.
- R4: Opcode 6'b111111 with displacement bit 0 = 1 is an unsigned halfword load: `mem_size` = 2'b01 and the datum is zero-extended.
- R5: With `in_valid` low, with any other opcode, or with opcode 6'b111111 and displacement bit 0 = 0, no request, no writeback and no misalignment flag are produced.
- R6: Memory is little-endian. A halfword at an address with bit 1 = 1 is taken from `mem_rdata[31:16]`; otherwise it is taken from `mem_rdata[15:0]`.
- R7: A halfword load to an odd address, or a word load to an address with bits 1:0 not 00, raises `misalign`, issues no memory request and does not raise `wb_valid`.
- R8: A load whose destination index is 0 still issues its request, but its writeback is discarded (`wb_valid` stays low).
- R9: A base index of 0 makes the base value read as zero, whatever `in_base` carries.
- R10: A load accepted in cycle c drives its request in cycle c+1 and its writeback or misalignment flag in cycle c+3. The read data arrives in cycle c+2. A new load may be accepted every cycle.
- R11: While `rst` is high and in the cycle after it, `mem_req`, `wb_valid` and `misalign` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_insn_hi | input | 16 | First instruction halfword (indices and opcode) |
| in_insn_lo | input | 16 | Second instruction halfword (displacement) |
| in_base | input | 32 | Value of the base register |
| mem_req | output | 1 | Read request to data memory |
| mem_addr | output | 32 | Byte address of the read |
| mem_size | output | 2 | 2'b01 halfword, 2'b10 word |
| mem_rdata | input | 32 | Read word, valid the cycle after the request |
| wb_valid | output | 1 | Destination write enable |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 32 | Extended load result |
| misalign | output | 1 | Misaligned access reported |

## Verification
The assertions assume that the instruction fields and base value are known whenever `in_valid` is high. They also assume that `mem_rdata` is the registered word for the address requested one cycle earlier. The stimulus holds the halfwords and base at defined idle values between loads. It models memory as a register loaded on the clock edge from the requested address, so the data always lands in the cycle after the request. Every byte of the model memory equals the low eight bits of its address, which makes lane choice and extension visible in the returned value.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  localparam int XLEN   = 32;
  localparam int HALF_W = 16;
  localparam int RIDX_W = 5;
  localparam int OPC_W  = 6;

  localparam logic [OPC_W-1:0] OPC_SW_HALF = 6'b111001;
  localparam logic [OPC_W-1:0] OPC_UHALF   = 6'b111111;

  typedef enum logic [1:0] {
    SZ_NONE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } ldu_size_e;

  typedef struct packed {
    logic              is_load;
    ldu_size_e         size;
    logic              sext;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rs;
    logic [HALF_W-1:0] disp;
  } ldu_dec_t;
endpackage

// File: rtl/ldu_decode.sv
module ldu_decode
  import ldu_pkg::*;
(
  input  logic [HALF_W-1:0] insn_hi,
  input  logic [HALF_W-1:0] insn_lo,
  output ldu_dec_t          dec
);
  localparam int RS_LO  = 0;
  localparam int OPC_LO = RS_LO + RIDX_W;
  localparam int RD_LO  = OPC_LO + OPC_W;

  logic [OPC_W-1:0] opc;
  logic             sel;

  assign opc = insn_hi[OPC_LO +: OPC_W];
  assign sel = insn_lo[0];

  always_comb begin
    dec.rd      = insn_hi[RD_LO +: RIDX_W];
    dec.rs      = insn_hi[RS_LO +: RIDX_W];
    dec.disp    = insn_lo;
    dec.is_load = 1'b0;
    dec.size    = SZ_NONE;
    dec.sext    = 1'b0;
    unique case (opc)
      OPC_SW_HALF: begin
        dec.is_load = 1'b1;
        dec.size    = sel ? SZ_WORD : SZ_HALF;
        dec.sext    = ~sel;
      end
      OPC_UHALF: begin
        if (sel) begin
          dec.is_load = 1'b1;
          dec.size    = SZ_HALF;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ldu_agen.sv
module ldu_agen
  import ldu_pkg::*;
#(
  parameter int AW = XLEN
)(
  input  logic [AW-1:0]     base,
  input  logic [RIDX_W-1:0] rs,
  input  logic [HALF_W-1:0] disp,
  input  ldu_size_e         size,
  output logic [AW-1:0]     ea,
  output logic              misal
);
  localparam int EXT_W = AW - HALF_W;

  logic [HALF_W-1:0] disp_even;
  logic [AW-1:0]     base_eff;
  logic [AW-1:0]     disp_ext;

  assign disp_even = {disp[HALF_W-1:1], 1'b0};
  assign base_eff  = (rs == '0) ? '0 : base;
  assign disp_ext  = {{EXT_W{disp_even[HALF_W-1]}}, disp_even};
  assign ea        = base_eff + disp_ext;

  always_comb begin
    unique case (size)
      SZ_HALF: misal = ea[0];
      SZ_WORD: misal = |ea[1:0];
      default: misal = 1'b0;
    endcase
  end
endmodule

// File: rtl/ldu_extract.sv
module ldu_extract
  import ldu_pkg::*;
#(
  parameter int DW = XLEN
)(
  input  logic [DW-1:0] rdata,
  input  logic          upper,
  input  ldu_size_e     size,
  input  logic          sext,
  output logic [DW-1:0] result
);
  localparam int EXT_W = DW - HALF_W;

  logic [HALF_W-1:0] half;

  assign half = upper ? rdata[HALF_W +: HALF_W] : rdata[0 +: HALF_W];

  always_comb begin
    if (size == SZ_WORD)
      result = rdata;
    else if (sext)
      result = {{EXT_W{half[HALF_W-1]}}, half};
    else
      result = {{EXT_W{1'b0}}, half};
  end
endmodule

// File: rtl/ldu_top.sv
module ldu_top
  import ldu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [15:0]       in_insn_hi,
  input  logic [15:0]       in_insn_lo,
  input  logic [31:0]       in_base,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  output logic [1:0]        mem_size,
  input  logic [31:0]       mem_rdata,
  output logic              wb_valid,
  output logic [4:0]        wb_idx,
  output logic [31:0]       wb_data,
  output logic              misalign
);
  ldu_dec_t    dec;
  logic [31:0] ea;
  logic        misal_c;
  logic [31:0] ext_data;

  ldu_decode u_dec (
    .insn_hi (in_insn_hi),
    .insn_lo (in_insn_lo),
    .dec     (dec)
  );

  ldu_agen #(.AW(XLEN)) u_agen (
    .base  (in_base),
    .rs    (dec.rs),
    .disp  (dec.disp),
    .size  (dec.size),
    .ea    (ea),
    .misal (misal_c)
  );

  // stage 1: request
  logic              s1_wb;
  logic              s1_mis;
  logic [RIDX_W-1:0] s1_rd;
  logic              s1_sext;
  ldu_size_e         s1_size;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
      mem_size <= SZ_NONE;
      s1_wb    <= 1'b0;
      s1_mis   <= 1'b0;
      s1_rd    <= '0;
      s1_sext  <= 1'b0;
      s1_size  <= SZ_NONE;
    end else begin
      mem_req  <= in_valid & dec.is_load & ~misal_c;
      mem_addr <= ea;
      mem_size <= dec.size;
      s1_wb    <= in_valid & dec.is_load & ~misal_c & (dec.rd != '0);
      s1_mis   <= in_valid & dec.is_load & misal_c;
      s1_rd    <= dec.rd;
      s1_sext  <= dec.sext;
      s1_size  <= dec.size;
    end
  end

  // stage 2: data return
  logic              s2_wb;
  logic              s2_mis;
  logic [RIDX_W-1:0] s2_rd;
  logic              s2_sext;
  logic              s2_upper;
  ldu_size_e         s2_size;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_wb    <= 1'b0;
      s2_mis   <= 1'b0;
      s2_rd    <= '0;
      s2_sext  <= 1'b0;
      s2_upper <= 1'b0;
      s2_size  <= SZ_NONE;
    end else begin
      s2_wb    <= s1_wb;
      s2_mis   <= s1_mis;
      s2_rd    <= s1_rd;
      s2_sext  <= s1_sext;
      s2_upper <= mem_addr[1];
      s2_size  <= s1_size;
    end
  end

  ldu_extract #(.DW(XLEN)) u_ext (
    .rdata  (mem_rdata),
    .upper  (s2_upper),
    .size   (s2_size),
    .sext   (s2_sext),
    .result (ext_data)
  );

  // stage 3: writeback
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_idx   <= '0;
      wb_data  <= '0;
      misalign <= 1'b0;
    end else begin
      wb_valid <= s2_wb;
      wb_idx   <= s2_rd;
      wb_data  <= ext_data;
      misalign <= s2_mis;
    end
  end

  // R7
  mis_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    misalign |-> !wb_valid);

  // R7
  req_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> ((mem_size == SZ_HALF && !mem_addr[0]) ||
                 (mem_size == SZ_WORD && mem_addr[1:0] == 2'b00)));

  // R8
  no_r0_wb_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> wb_idx != '0);

  // R10
  wb_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(mem_req, 2));

  // R5
  req_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> $past(in_valid));

  // R2
  half_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (s2_size == SZ_HALF) |=> (wb_data[31:16] == 16'h0000 ||
                              wb_data[31:16] == 16'hFFFF));
endmodule

// File: tb/tb_ldu_top.sv
module tb_ldu_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [15:0] in_insn_hi, in_insn_lo;
  logic [31:0] in_base;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [1:0]  mem_size;
  logic [31:0] mem_rdata;
  logic        wb_valid;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;
  logic        misalign;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ldu_top dut (.*);

  // model memory: each byte holds the low 8 bits of its address
  always @(posedge clk)
    if (mem_req)
      mem_rdata <= {mem_addr[7:2], 2'd3, mem_addr[7:2], 2'd2,
                    mem_addr[7:2], 2'd1, mem_addr[7:2], 2'd0};

  // kind: 0 nothing, 1 writeback, 2 misaligned, 3 request without writeback
  typedef struct packed {
    logic [15:0] hi;
    logic [15:0] lo;
    logic [31:0] base;
    logic [1:0]  kind;
    logic [1:0]  size;
    logic [4:0]  rd;
    logic [31:0] addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{16'h1F21, 16'h0080, 32'h0000_0100, 2'd1, 2'b01, 5'd3,  32'h0000_0180, 32'hFFFF_8180},
    '{16'h27E2, 16'h0081, 32'h0000_0200, 2'd1, 2'b01, 5'd4,  32'h0000_0280, 32'h0000_8180},
    '{16'h2F26, 16'h0011, 32'h0000_1000, 2'd1, 2'b10, 5'd5,  32'h0000_1010, 32'h1312_1110},
    '{16'h3F28, 16'hFFF1, 32'h0000_2000, 2'd1, 2'b10, 5'd7,  32'h0000_1FF0, 32'hF3F2_F1F0},
    '{16'h4F2A, 16'h0070, 32'h0000_3002, 2'd1, 2'b01, 5'd9,  32'h0000_3072, 32'h0000_7372},
    '{16'h5F2C, 16'h0000, 32'h0000_0101, 2'd2, 2'b01, 5'd11, 32'h0,         32'h0},
    '{16'h6F2E, 16'h0001, 32'h0000_0202, 2'd2, 2'b10, 5'd13, 32'h0,         32'h0},
    '{16'h7FF0, 16'h0005, 32'h0000_40FE, 2'd1, 2'b01, 5'd15, 32'h0000_4102, 32'h0000_0302},
    '{16'h0721, 16'h0001, 32'h0000_0500, 2'd3, 2'b10, 5'd0,  32'h0000_0500, 32'h0},
    '{16'h8F20, 16'h0021, 32'h1234_5678, 2'd1, 2'b10, 5'd17, 32'h0000_0020, 32'h2322_2120},
    '{16'h97E1, 16'h0010, 32'h0000_0100, 2'd0, 2'b00, 5'd18, 32'h0,         32'h0},
    '{16'h9801, 16'h0001, 32'h0000_0100, 2'd0, 2'b00, 5'd19, 32'h0,         32'h0},
    '{16'hA7E3, 16'h0085, 32'h0000_00FE, 2'd1, 2'b01, 5'd20, 32'h0000_0182, 32'h0000_8382},
    '{16'hAF24, 16'h8001, 32'h0000_0010, 2'd1, 2'b10, 5'd21, 32'hFFFF_8010, 32'h1312_1110}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_valid   = 1'b1;
    in_insn_hi = v.hi;
    in_insn_lo = v.lo;
    in_base    = v.base;
  endtask

  task automatic idle();
    in_valid   = 1'b0;
    in_insn_hi = 16'h0000;
    in_insn_lo = 16'h0000;
    in_base    = 32'h0;
  endtask

  task automatic check_req(input vec_t v, input string tag);
    logic exp_req;
    exp_req = (v.kind == 2'd1 || v.kind == 2'd3);
    chk({tag, " R5/R7 mem_req"}, {31'b0, mem_req}, {31'b0, exp_req});
    if (exp_req) begin
      chk({tag, " R1 mem_addr"}, mem_addr, v.addr);
      chk({tag, " R2/R3/R4 mem_size"}, {30'b0, mem_size}, {30'b0, v.size});
    end
  endtask

  task automatic check_wb(input vec_t v, input string tag);
    chk({tag, " R8 wb_valid"}, {31'b0, wb_valid}, {31'b0, v.kind == 2'd1});
    chk({tag, " R7 misalign"}, {31'b0, misalign}, {31'b0, v.kind == 2'd2});
    if (v.kind == 2'd1) begin
      chk({tag, " R10 wb_idx"}, {27'b0, wb_idx}, {27'b0, v.rd});
      chk({tag, " R6 wb_data"}, wb_data, v.data);
    end
  endtask

  bit done = 1'b0;

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 mem_req in reset", {31'b0, mem_req}, 32'h0);
    chk("R11 wb_valid in reset", {31'b0, wb_valid}, 32'h0);
    chk("R11 misalign in reset", {31'b0, misalign}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 mem_req after reset", {31'b0, mem_req}, 32'h0);
    chk("R11 wb_valid after reset", {31'b0, wb_valid}, 32'h0);

    // table walk: one load at a time, R10 timing c+1 request, c+3 result
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      idle();
      check_req(VEC[i], $sformatf("vec%0d", i));
      @(negedge clk);
      @(negedge clk);
      check_wb(VEC[i], $sformatf("vec%0d", i));
      @(negedge clk);
      chk("R5 idle no wb", {31'b0, wb_valid | misalign}, 32'h0);
    end

    // R10: back-to-back issue, one per clock, mixed kinds
    drive(VEC[0]); @(negedge clk);
    check_req(VEC[0], "stream0");
    drive(VEC[2]); @(negedge clk);
    check_req(VEC[2], "stream1");
    drive(VEC[5]); @(negedge clk);
    check_req(VEC[5], "stream2");
    check_wb(VEC[0], "stream0 R10");
    drive(VEC[12]); @(negedge clk);
    idle();
    check_req(VEC[12], "stream3");
    check_wb(VEC[2], "stream1 R10");
    @(negedge clk);
    check_wb(VEC[5], "stream2 R10");
    @(negedge clk);
    check_wb(VEC[12], "stream3 R10");

    // R9: base index 0 with a huge base value still addresses from zero
    drive('{16'h8F20, 16'h0041, 32'hFFFF_FFFF, 2'd1, 2'b10, 5'd17, 32'h0000_0040, 32'h4342_4140});
    @(negedge clk);
    idle();
    chk("R9 base index zero addr", mem_addr, 32'h0000_0040);

    // R5: a load pattern with in_valid low produces nothing
    repeat (2) @(negedge clk);
    in_valid = 1'b0; in_insn_hi = 16'h2F26; in_insn_lo = 16'h0011; in_base = 32'h1000;
    @(negedge clk);
    chk("R5 no request without valid", {31'b0, mem_req}, 32'h0);
    idle();
    repeat (2) @(negedge clk);
    chk("R5 no wb without valid", {31'b0, wb_valid | misalign}, 32'h0);

    // R11: reset in flight discards a pending load
    drive(VEC[2]); @(negedge clk);
    idle(); rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset flushes wb", {31'b0, wb_valid}, 32'h0);
    @(negedge clk);
    chk("R11 reset flushes wb later", {31'b0, wb_valid}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule